// File: doc/BRIEF.md
# Address Entry Allocation Search Engine

This block decides where a forwarding-table entry goes. A request carries a 48-bit MAC address, a 12-bit VLAN identifier, a flag that says whether the VLAN applies, and an entry image that is already prepared. The block walks the external lookup table one slot per cycle through a table read port. It picks the target slot in a strict order of preference. An entry that already holds the same address and VLAN comes first. A free slot comes next. Last comes a dynamic unicast entry that may be evicted. The block then writes the finished entry through the table write port. When none of the three searches finds a slot, it reports that the table is full instead.

Delete requests use the same match search. A hit writes an all-zero (free) entry at the matching slot. A miss reports that the entry was not found. Requests are taken only while the block is idle. The result index and status appear together with a one-cycle done pulse.

Top module: `alloc_search_engine`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and tbl_wr_en is 0.
- R2: A slot matches only when all three of these hold. Its type field [61:60] is 1 (address) or 3 (VLAN address). Its VLAN field [59:48] equals the lookup VLAN, which is req_vlan when req_vlan_en is 1 and 0 otherwise. Its MAC field equals the request. MAC byte i sits at bits 40-8i+7 down to 40-8i, so byte 0 (req_mac[47:40]) is at [47:40]. An entry with type 0 or 2, or with a different VLAN, or with any byte different, does not match.
- R3: An insert (req_op 0) uses the lowest-index matching slot, even when free slots exist. If that slot is index k, done rises k+1 clock edges after the accepting edge.
- R4: If no slot matches, an insert uses the lowest-index slot whose type is 0. If that slot is index k, done rises DEPTH+k+1 edges after acceptance.
- R5: If there is also no free slot, an insert uses the lowest-index evictable slot. A slot is evictable when its type is 1 or 3, bit 40 is clear, and the field [63:62] is neither 0 nor 2. If that slot is index k, done rises 2*DEPTH+k+1 edges after acceptance.
- R6: If all three searches fail, done rises 3*DEPTH edges after acceptance with done_status 1 (full), and no table write takes place.
- R7: An inserted entry equals req_image with three fields replaced. Bits [47:0] become req_mac. When req_vlan_en is 0, the type becomes 1 and the VLAN field becomes 0. When req_vlan_en is 1, the type becomes 3 and the VLAN field becomes req_vlan.
- R8: A delete (req_op 1) that hits the lowest matching index k writes all zeros to slot k and reports done_status 0 (ok), k+1 edges after acceptance.
- R9: A delete with no match reports done_status 2 (not found) DEPTH edges after acceptance and writes nothing.
- R10: req_ready is 1 only while idle. req_valid is ignored while busy. done is high for exactly one cycle, carrying done_idx and done_status. Any table write happens in that same cycle, at done_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_op | input | 1 | 0 insert, 1 delete |
| req_mac | input | 48 | MAC address, byte 0 in [47:40] |
| req_vlan | input | 12 | VLAN identifier |
| req_vlan_en | input | 1 | VLAN applies to lookup and written entry |
| req_image | input | 68 | Prepared entry image for insert |
| done | output | 1 | One-cycle completion pulse |
| done_idx | output | IDX_W | Chosen slot index |
| done_status | output | 2 | 0 ok, 1 full, 2 not found |
| tbl_rd_idx | output | IDX_W | Table slot being read |
| tbl_rd_data | input | 68 | Contents of slot tbl_rd_idx, same cycle |
| tbl_wr_en | output | 1 | Table write strobe |
| tbl_wr_idx | output | IDX_W | Table write slot |
| tbl_wr_data | output | 68 | Table write data |

## Verification
The bench fills the table with decoy entries that each fail exactly one match condition: wrong type, wrong VLAN, or a differing last MAC byte. It places them ahead of the true match, so a match that ignores any one field is caught. Separate table layouts make each insert end in a different stage: a match ahead of free slots, only free slots, only evictable candidates among persistent, OUI, multicast and VLAN entries, or nothing at all. The measured latency tells which stage found the slot. Delete hits and misses confirm a zeroed slot or an untouched table. Requests driven while a scan is running confirm that only the first request takes effect.

// File: rtl/alloc_pkg.sv
package alloc_pkg;

    localparam int ENTRY_W   = 68;
    localparam int MAC_W     = 48;
    localparam int VID_W     = 12;
    localparam int MAC_BYTES = MAC_W / 8;
    localparam int BYTE0_LO  = 40;
    localparam int VID_LO    = 48;
    localparam int TYPE_LO   = 60;
    localparam int UCT_LO    = 62;
    localparam int MCAST_BIT = 40;

    typedef enum logic [1:0] {
        ETYPE_FREE  = 2'd0,
        ETYPE_ADDR  = 2'd1,
        ETYPE_VLAN  = 2'd2,
        ETYPE_VADDR = 2'd3
    } etype_e;

    typedef enum logic [1:0] {
        STAT_OK       = 2'd0,
        STAT_FULL     = 2'd1,
        STAT_NOTFOUND = 2'd2
    } status_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_MATCH,
        PH_FREE,
        PH_EVICT,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic               del;
        logic [MAC_W-1:0]   mac;
        logic [VID_W-1:0]   vid;
        logic               vlan_en;
        logic [ENTRY_W-1:0] image;
    } req_t;

    function automatic logic [1:0] entry_type(input logic [ENTRY_W-1:0] e);
        return e[TYPE_LO +: 2];
    endfunction

    function automatic logic type_has_addr(input logic [1:0] t);
        return (t == ETYPE_ADDR) || (t == ETYPE_VADDR);
    endfunction

    function automatic logic [VID_W-1:0] lookup_vid(input req_t r);
        return r.vlan_en ? r.vid : '0;
    endfunction

endpackage

// File: rtl/alloc_slot_eval.sv
module alloc_slot_eval
    import alloc_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic [MAC_W-1:0]   mac,
    input  logic [VID_W-1:0]   vid,
    output logic               is_match,
    output logic               is_free,
    output logic               is_evict
);

    logic [MAC_BYTES-1:0] byte_eq;
    logic [1:0]           etype;
    logic [1:0]           ucast;
    logic                 addr_kind;
    logic [3:0]           unused_hi;

    assign unused_hi = entry[ENTRY_W-1 -: 4];

    for (genvar b = 0; b < MAC_BYTES; b++) begin : g_byte
        localparam int LO = BYTE0_LO - 8 * b;
        assign byte_eq[b] = (entry[LO +: 8] == mac[LO +: 8]);
    end

    assign etype     = entry_type(entry);
    assign ucast     = entry[UCT_LO +: 2];
    assign addr_kind = type_has_addr(etype);

    assign is_match = addr_kind && (entry[VID_LO +: VID_W] == vid) && (&byte_eq);
    assign is_free  = (etype == ETYPE_FREE);
    assign is_evict = addr_kind && !entry[MCAST_BIT]
                      && (ucast != 2'd0) && (ucast != 2'd2);

endmodule

// File: rtl/alloc_entry_fmt.sv
module alloc_entry_fmt
    import alloc_pkg::*;
(
    input  req_t               req,
    output logic [ENTRY_W-1:0] wr_data
);

    always_comb begin
        if (req.del) begin
            wr_data = '0;
        end else begin
            wr_data                   = req.image;
            wr_data[TYPE_LO +: 2]     = req.vlan_en ? ETYPE_VADDR : ETYPE_ADDR;
            wr_data[VID_LO +: VID_W]  = lookup_vid(req);
            wr_data[MAC_W-1:0]        = req.mac;
        end
    end

endmodule

// File: rtl/alloc_scan_ctrl.sv
module alloc_scan_ctrl
    import alloc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             op_del,
    input  logic             is_match,
    input  logic             is_free,
    input  logic             is_evict,
    output logic             ready,
    output logic             accept,
    output logic [IDX_W-1:0] scan_idx,
    output logic             done,
    output logic [IDX_W-1:0] res_idx,
    output logic [1:0]       res_status,
    output logic             wr_en
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    phase_e           phase_q;
    logic [IDX_W-1:0] scan_q;
    logic [IDX_W-1:0] hit_q;
    status_e          stat_q;
    logic             at_last;

    assign at_last = (scan_q == LAST_IDX);
    assign ready   = (phase_q == PH_IDLE);
    assign accept  = ready && req_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            scan_q  <= '0;
            hit_q   <= '0;
            stat_q  <= STAT_OK;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (req_valid) begin
                        phase_q <= PH_MATCH;
                        scan_q  <= '0;
                    end
                end
                PH_MATCH: begin
                    if (is_match) begin
                        hit_q   <= scan_q;
                        stat_q  <= STAT_OK;
                        phase_q <= PH_DONE;
                    end else if (at_last) begin
                        scan_q <= '0;
                        if (op_del) begin
                            hit_q   <= '0;
                            stat_q  <= STAT_NOTFOUND;
                            phase_q <= PH_DONE;
                        end else begin
                            phase_q <= PH_FREE;
                        end
                    end else begin
                        scan_q <= scan_q + 1'b1;
                    end
                end
                PH_FREE: begin
                    if (is_free) begin
                        hit_q   <= scan_q;
                        stat_q  <= STAT_OK;
                        phase_q <= PH_DONE;
                    end else if (at_last) begin
                        scan_q  <= '0;
                        phase_q <= PH_EVICT;
                    end else begin
                        scan_q <= scan_q + 1'b1;
                    end
                end
                PH_EVICT: begin
                    if (is_evict) begin
                        hit_q   <= scan_q;
                        stat_q  <= STAT_OK;
                        phase_q <= PH_DONE;
                    end else if (at_last) begin
                        scan_q  <= '0;
                        hit_q   <= '0;
                        stat_q  <= STAT_FULL;
                        phase_q <= PH_DONE;
                    end else begin
                        scan_q <= scan_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    scan_q  <= '0;
                end
            endcase
        end
    end

    assign scan_idx   = scan_q;
    assign done       = (phase_q == PH_DONE);
    assign res_idx    = hit_q;
    assign res_status = stat_q;
    assign wr_en      = done && (stat_q == STAT_OK);

endmodule

// File: rtl/alloc_search_engine.sv
module alloc_search_engine
    import alloc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_op,
    input  logic [MAC_W-1:0]   req_mac,
    input  logic [VID_W-1:0]   req_vlan,
    input  logic               req_vlan_en,
    input  logic [ENTRY_W-1:0] req_image,
    output logic               done,
    output logic [IDX_W-1:0]   done_idx,
    output logic [1:0]         done_status,
    output logic [IDX_W-1:0]   tbl_rd_idx,
    input  logic [ENTRY_W-1:0] tbl_rd_data,
    output logic               tbl_wr_en,
    output logic [IDX_W-1:0]   tbl_wr_idx,
    output logic [ENTRY_W-1:0] tbl_wr_data
);

    req_t req_q;
    logic accept;
    logic hit_match, hit_free, hit_evict;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q.del     <= req_op;
            req_q.mac     <= req_mac;
            req_q.vid     <= req_vlan;
            req_q.vlan_en <= req_vlan_en;
            req_q.image   <= req_image;
        end
    end

    alloc_slot_eval u_eval (
        .entry    (tbl_rd_data),
        .mac      (req_q.mac),
        .vid      (lookup_vid(req_q)),
        .is_match (hit_match),
        .is_free  (hit_free),
        .is_evict (hit_evict)
    );

    alloc_scan_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .op_del     (req_q.del),
        .is_match   (hit_match),
        .is_free    (hit_free),
        .is_evict   (hit_evict),
        .ready      (req_ready),
        .accept     (accept),
        .scan_idx   (tbl_rd_idx),
        .done       (done),
        .res_idx    (done_idx),
        .res_status (done_status),
        .wr_en      (tbl_wr_en)
    );

    alloc_entry_fmt u_fmt (
        .req     (req_q),
        .wr_data (tbl_wr_data)
    );

    assign tbl_wr_idx = done_idx;

endmodule

// File: rtl/alloc_search_sva.sv
module alloc_search_sva
    import alloc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic               req_op,
    input logic [MAC_W-1:0]   req_mac,
    input logic               req_vlan_en,
    input logic               done,
    input logic [IDX_W-1:0]   done_idx,
    input logic [1:0]         done_status,
    input logic               tbl_wr_en,
    input logic [IDX_W-1:0]   tbl_wr_idx,
    input logic [ENTRY_W-1:0] tbl_wr_data
);

    logic             cur_del;
    logic             cur_en;
    logic [MAC_W-1:0] cur_mac;
    int unsigned      wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_del  <= 1'b0;
            cur_en   <= 1'b0;
            cur_mac  <= '0;
            wait_cnt <= 0;
        end else if (req_valid && req_ready) begin
            cur_del  <= req_op;
            cur_en   <= req_vlan_en;
            cur_mac  <= req_mac;
            wait_cnt <= 0;
        end else begin
            wait_cnt <= wait_cnt + 1;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> !req_ready); // R10
    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (rst) done |-> !req_ready); // R10
    AST_WRITE_AT_DONE: assert property (@(posedge clk) disable iff (rst) tbl_wr_en |-> (done && done_status == 2'd0 && tbl_wr_idx == done_idx)); // R10
    AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (rst) (done && done_status != 2'd0) |-> !tbl_wr_en); // R6
    AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (rst) done |-> (wait_cnt <= 3 * DEPTH)); // R6
    AST_INS_MAC: assert property (@(posedge clk) disable iff (rst) (tbl_wr_en && !cur_del) |-> (tbl_wr_data[MAC_W-1:0] == cur_mac)); // R7
    AST_INS_TYPE: assert property (@(posedge clk) disable iff (rst) (tbl_wr_en && !cur_del) |-> (tbl_wr_data[TYPE_LO +: 2] == (cur_en ? 2'd3 : 2'd1))); // R7
    AST_DEL_ZERO: assert property (@(posedge clk) disable iff (rst) (tbl_wr_en && cur_del) |-> (tbl_wr_data == '0)); // R8
    AST_DEL_NEVER_FULL: assert property (@(posedge clk) disable iff (rst) (done && cur_del) |-> (done_status != 2'd1)); // R9

endmodule

bind alloc_search_engine alloc_search_sva #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_sva (.*);

// File: tb/tb_alloc_search_engine.sv
module tb_alloc_search_engine;

    localparam int DEPTH = 16;
    localparam int IDX_W = 4;
    localparam int EW    = 68;

    logic            clk = 1'b0;
    logic            rst;
    logic            req_valid;
    logic            req_ready;
    logic            req_op;
    logic [47:0]     req_mac;
    logic [11:0]     req_vlan;
    logic            req_vlan_en;
    logic [EW-1:0]   req_image;
    logic            done;
    logic [IDX_W-1:0] done_idx;
    logic [1:0]      done_status;
    logic [IDX_W-1:0] tbl_rd_idx;
    logic [EW-1:0]   tbl_rd_data;
    logic            tbl_wr_en;
    logic [IDX_W-1:0] tbl_wr_idx;
    logic [EW-1:0]   tbl_wr_data;

    logic [EW-1:0] mem [DEPTH];
    int wr_count = 0;
    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    assign tbl_rd_data = mem[tbl_rd_idx];

    always @(posedge clk) begin
        if (tbl_wr_en) begin
            mem[tbl_wr_idx] <= tbl_wr_data;
            wr_count <= wr_count + 1;
        end
    end

    alloc_search_engine #(.DEPTH(DEPTH)) dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [EW-1:0] act, input logic [EW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [EW-1:0] ent(input logic [1:0] t, input logic [11:0] v,
                                          input logic [47:0] m, input logic [1:0] u);
        logic [EW-1:0] e;
        e = '0;
        e[63:62] = u;
        e[61:60] = t;
        e[59:48] = v;
        e[47:0]  = m;
        return e;
    endfunction

    task automatic fill(input logic [EW-1:0] e_base);
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = e_base;
            mem[i][15:8] = 8'(i + 1);
        end
    endtask

    task automatic run_req(input logic op, input logic [47:0] mac, input logic [11:0] vid,
                           input logic en, input logic [EW-1:0] img,
                           output int n, output logic [IDX_W-1:0] idx, output logic [1:0] st);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_mac = mac; req_vlan = vid;
        req_vlan_en = en; req_image = img;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (1) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (done) break;
        end
        idx = done_idx;
        st  = done_status;
        @(posedge clk);
        @(negedge clk);
    endtask

    localparam logic [47:0] MAC_A = 48'h02_11_22_33_44_56;

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 ready", EW'(req_ready), 1);
        chk(done == 1'b0, "R1 done", EW'(done), 0);
        chk(tbl_wr_en == 1'b0, "R1 wr_en", EW'(tbl_wr_en), 0);
    endtask

    task automatic t_match();
        int n; logic [IDX_W-1:0] idx; logic [1:0] st;
        logic [EW-1:0] img, expv;
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        mem[0] = ent(2'd1, 12'd0, MAC_A ^ 48'h1, 2'd1);
        mem[1] = ent(2'd3, 12'd7, MAC_A, 2'd1);
        mem[2] = ent(2'd2, 12'd0, MAC_A, 2'd1);
        mem[3] = ent(2'd1, 12'd0, MAC_A, 2'd0);
        img = '0; img[67:64] = 4'h5; img[63:62] = 2'b01;
        run_req(1'b0, MAC_A, 12'h3C5, 1'b0, img, n, idx, st);
        chk(idx == 4'd3, "R2 R3 match index", EW'(idx), 3);
        chk(n == 4, "R3 match latency", EW'(n), 4);
        chk(st == 2'd0, "R3 status", EW'(st), 0);
        expv = {4'h5, 2'b01, 2'b01, 12'h000, MAC_A};
        chk(mem[3] == expv, "R7 flag-clear image", mem[3], expv);
        chk(mem[4] == '0, "R3 free slot untouched", mem[4], 0);
        run_req(1'b0, MAC_A, 12'd7, 1'b1, img, n, idx, st);
        chk(idx == 4'd1, "R2 R3 vlan match index", EW'(idx), 1);
        chk(n == 2, "R3 vlan match latency", EW'(n), 2);
        expv = {4'h5, 2'b01, 2'b11, 12'd7, MAC_A};
        chk(mem[1] == expv, "R7 flag-set image", mem[1], expv);
    endtask

    task automatic t_free();
        int n; logic [IDX_W-1:0] idx; logic [1:0] st;
        logic [EW-1:0] img, expv;
        fill(ent(2'd1, 12'd0, 48'h0A_00_00_00_00_00, 2'd0));
        mem[6] = '0; mem[9] = '0;
        img = {4'hA, 2'b11, 2'b10, 12'hABC, 48'h0};
        run_req(1'b0, 48'h0C_DE_AD_BE_EF_00, 12'h0, 1'b0, img, n, idx, st);
        chk(idx == 4'd6, "R4 free index", EW'(idx), 6);
        chk(n == DEPTH + 7, "R4 free latency", EW'(n), DEPTH + 7);
        expv = {4'hA, 2'b11, 2'b01, 12'h000, 48'h0C_DE_AD_BE_EF_00};
        chk(mem[6] == expv, "R7 image overrides", mem[6], expv);
        chk(mem[9] == '0, "R4 later free untouched", mem[9], 0);
    endtask

    task automatic t_evict();
        int n; logic [IDX_W-1:0] idx; logic [1:0] st;
        int wc;
        fill(ent(2'd1, 12'd0, 48'h0A_00_00_00_00_00, 2'd0));
        mem[1] = ent(2'd1, 12'd0, 48'h0A_00_00_00_01_00, 2'd2);
        mem[2] = ent(2'd1, 12'd0, 48'h01_00_00_00_02_00, 2'd3);
        mem[3] = ent(2'd2, 12'd0, 48'h0A_00_00_00_03_00, 2'd3);
        mem[4] = ent(2'd3, 12'd4, 48'h0A_00_00_00_04_00, 2'd1);
        mem[8] = ent(2'd1, 12'd0, 48'h0A_00_00_00_08_00, 2'd3);
        wc = wr_count;
        run_req(1'b0, 48'h0E_00_00_00_00_77, 12'h0, 1'b0, '0, n, idx, st);
        chk(idx == 4'd4, "R5 evict index", EW'(idx), 4);
        chk(n == 2 * DEPTH + 5, "R5 evict latency", EW'(n), 2 * DEPTH + 5);
        chk(st == 2'd0, "R5 status", EW'(st), 0);
        chk(mem[4][47:0] == 48'h0E_00_00_00_00_77, "R5 evicted slot rewritten", EW'(mem[4][47:0]), EW'(48'h0E_00_00_00_00_77));
        chk(wr_count == wc + 1, "R5 single write", EW'(wr_count - wc), 1);
    endtask

    task automatic t_full();
        int n; logic [IDX_W-1:0] idx; logic [1:0] st;
        logic [EW-1:0] snap [DEPTH];
        int wc; int diffs;
        fill(ent(2'd1, 12'd0, 48'h0A_00_00_00_00_00, 2'd0));
        mem[5] = ent(2'd1, 12'd0, 48'h01_00_00_00_05_00, 2'd1);
        for (int i = 0; i < DEPTH; i++) snap[i] = mem[i];
        wc = wr_count;
        run_req(1'b0, 48'h0E_00_00_00_00_99, 12'h0, 1'b0, '0, n, idx, st);
        chk(st == 2'd1, "R6 full status", EW'(st), 1);
        chk(n == 3 * DEPTH, "R6 full latency", EW'(n), 3 * DEPTH);
        chk(wr_count == wc, "R6 no write", EW'(wr_count - wc), 0);
        diffs = 0;
        for (int i = 0; i < DEPTH; i++) if (mem[i] != snap[i]) diffs++;
        chk(diffs == 0, "R6 table unchanged", EW'(diffs), 0);
    endtask

    task automatic t_delete();
        int n; logic [IDX_W-1:0] idx; logic [1:0] st;
        int wc;
        fill(ent(2'd1, 12'd0, 48'h0A_00_00_00_00_00, 2'd0));
        mem[7]  = ent(2'd3, 12'h123, MAC_A, 2'd0);
        mem[11] = ent(2'd3, 12'h123, MAC_A, 2'd0);
        run_req(1'b1, MAC_A, 12'h123, 1'b1, '1, n, idx, st);
        chk(idx == 4'd7, "R8 delete index", EW'(idx), 7);
        chk(n == 8, "R8 delete latency", EW'(n), 8);
        chk(st == 2'd0, "R8 delete status", EW'(st), 0);
        chk(mem[7] == '0, "R8 slot zeroed", mem[7], 0);
        chk(mem[11] != '0, "R8 later duplicate kept", mem[11], ent(2'd3, 12'h123, MAC_A, 2'd0));
        wc = wr_count;
        run_req(1'b1, MAC_A, 12'h124, 1'b1, '0, n, idx, st);
        chk(st == 2'd2, "R9 miss status", EW'(st), 2);
        chk(n == DEPTH, "R9 miss latency", EW'(n), DEPTH);
        chk(wr_count == wc, "R9 no write", EW'(wr_count - wc), 0);
    endtask

    task automatic t_busy();
        int n; int wc; int busy_ready;
        fill(ent(2'd1, 12'd0, 48'h0A_00_00_00_00_00, 2'd0));
        mem[2] = '0;
        wc = wr_count;
        @(negedge clk);
        req_valid = 1'b1; req_op = 1'b1; req_mac = 48'h0F_00_00_00_00_01;
        req_vlan = 12'h0; req_vlan_en = 1'b0; req_image = '0;
        @(posedge clk);
        @(negedge clk);
        req_op = 1'b0; req_mac = 48'h0F_00_00_00_00_02;
        n = 0; busy_ready = 0;
        while (1) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 5) req_valid = 1'b0;
            if (req_ready) busy_ready++;
            if (done) break;
        end
        chk(done_status == 2'd2, "R10 first request kept", EW'(done_status), 2);
        chk(n == DEPTH, "R10 busy latency", EW'(n), DEPTH);
        chk(busy_ready == 0, "R10 ready low while busy", EW'(busy_ready), 0);
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", EW'(done), 0);
        chk(req_ready == 1'b1, "R10 ready after done", EW'(req_ready), 1);
        chk(wr_count == wc && mem[2] == '0, "R10 ignored insert wrote nothing", EW'(wr_count - wc), 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        rst = 1'b1; req_valid = 1'b0; req_op = 1'b0; req_mac = '0;
        req_vlan = '0; req_vlan_en = 1'b0; req_image = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_match();
        t_free();
        t_evict();
        t_full();
        t_delete();
        t_busy();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule